// File: doc/BRIEF.md
# Dual-Mode Divider Configuration Loader

This block holds the divide settings of a clock synthesizer: a feedback divide value M, an output divide value N and a two-bit test selection. Software or board logic can set them in two ways, and both ways write the same register set.

In the parallel path, an active-low strobe makes the M and N input buses transparent to the registers for as long as it is low. The values present when it rises are kept. In the serial path, a slow serial clock shifts a 13-bit word into a shift register. A rise of the serial load strobe moves that word into the registers, and its fall freezes them. While the serial load strobe stays high, each serial clock edge shifts one bit and writes the new shift contents straight into the registers (pass-through).

A test output multiplexer, steered by the test bits, exposes a constant low, the serial data pin, the feedback divider output or the synthesized clock. A flag reports whether the held M lies in the range for which the loop can lock. All strobes, the serial clock and the serial data are brought into a fast system clock domain by synchronizers, and every edge is detected in that domain.

Top module: `divcfg_loader`

## Requirements
- R1: A synchronous reset sets M to 200, N to 0 and the test selection to 00; m_valid is then high.
- R2: While par_load_n is low, m_reg and n_reg follow par_m and par_n within a few system clocks.
- R3: When par_load_n rises, the parallel values are kept. Later changes on par_m and par_n have no effect on m_reg and n_reg.
- R4: With par_load_n high and ser_load low, each rising ser_clk shifts ser_data into a 13-bit shift register, and the held registers do not change. A rise of ser_load transfers the word. The word is sent first bit first in the order T1, T0, N1, N0, M8 down to M0, so bits [12:11] are the test selection, bits [10:9] are N and bits [8:0] are M.
- R5: After ser_load falls, further serial clocks change only the shift register; m_reg, n_reg and tsel keep their values.
- R6: While ser_load is high, each rising ser_clk shifts one bit in and writes the new 13-bit shift contents to the registers in the same bit layout as R4.
- R7: While par_load_n is low, tsel reads 00, and serial clocks and serial load edges do not change the registers.
- R8: test_out is 0 for tsel 00, ser_data for 01, fb_div_in for 10 and synth_clk_in for 11.
- R9: m_valid is high exactly when m_reg lies from 125 to 350 inclusive.
- R10: When more than 13 bits are shifted before ser_load rises, only the last 13 bits received are transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous reset, active high |
| par_load_n | input | 1 | Parallel load strobe, active low (transparent while low) |
| par_m | input | 9 | Parallel feedback divide value |
| par_n | input | 2 | Parallel output divide value |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data bit |
| ser_load | input | 1 | Serial load strobe |
| fb_div_in | input | 1 | Feedback divider output, observed by the test mux |
| synth_clk_in | input | 1 | Synthesized clock, observed by the test mux |
| m_reg | output | 9 | Held feedback divide value |
| n_reg | output | 2 | Held output divide value |
| tsel | output | 2 | Held test selection |
| test_out | output | 1 | Test multiplexer output |
| m_valid | output | 1 | M lies in the lockable range |

## Verification
The bound checker checks these properties on every cycle: the reset values, the forced 00 test selection in parallel mode, the stability of the registers when no load path is active, the low and feedback-divider legs of the test multiplexer, and the rejection of M values below the lock range. The bench scenarios are needed for the rest: the bit order of the serial word, which bits survive an over-long shift, the bit-by-bit pass-through updates, the latching on a parallel strobe rise, and the exact edges of the lock range.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;

   // Default field widths of the configuration word
   localparam int CFG_M_W = 9;
   localparam int CFG_N_W = 2;
   localparam int CFG_T_W = 2;

   // Test multiplexer selection codes
   typedef enum logic [1:0] {
      TSEL_LOW   = 2'b00,
      TSEL_SDATA = 2'b01,
      TSEL_FBDIV = 2'b10,
      TSEL_SYNTH = 2'b11
   } tsel_e;

endpackage

// File: rtl/divcfg_sync.sv
module divcfg_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("divcfg_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) stage[0] <= RST_VAL;
            else     stage[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) stage[i] <= RST_VAL;
            else     stage[i] <= stage[i-1];
         end
      end
   end

   assign q = stage[STAGES-1];

endmodule

// File: rtl/divcfg_edge.sv
module divcfg_edge #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic lvl,
   output logic rise,
   output logic fall
);

   logic prev;

   always_ff @(posedge clk) begin
      if (rst) prev <= RST_VAL;
      else     prev <= lvl;
   end

   assign rise = lvl & ~prev;
   assign fall = ~lvl & prev;

endmodule

// File: rtl/divcfg_shift.sv
module divcfg_shift #(
   parameter int W = 13
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic         din,
   output logic [W-1:0] word,
   output logic [W-1:0] word_next
);

   if (W < 2) begin : g_bad_w
      $error("divcfg_shift: W must be at least 2");
   end

   assign word_next = {word[W-2:0], din};

   always_ff @(posedge clk) begin
      if (rst)     word <= '0;
      else if (en) word <= word_next;
   end

endmodule

// File: rtl/divcfg_testmux.sv
module divcfg_testmux
   import divcfg_pkg::*;
(
   input  logic [1:0] sel,
   input  logic       sdata_in,
   input  logic       fb_in,
   input  logic       synth_in,
   output logic       out
);

   always_comb begin
      unique case (tsel_e'(sel))
         TSEL_LOW:   out = 1'b0;
         TSEL_SDATA: out = sdata_in;
         TSEL_FBDIV: out = fb_in;
         TSEL_SYNTH: out = synth_in;
         default:    out = 1'b0;
      endcase
   end

endmodule

// File: rtl/divcfg_loader.sv
module divcfg_loader
   import divcfg_pkg::*;
#(
   parameter int M_W         = CFG_M_W,
   parameter int N_W         = CFG_N_W,
   parameter int T_W         = CFG_T_W,
   parameter int SYNC_STAGES = 2,
   parameter int M_LOCK_MIN  = 125,
   parameter int M_LOCK_MAX  = 350,
   parameter int M_RESET     = 200
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           par_load_n,
   input  logic [M_W-1:0] par_m,
   input  logic [N_W-1:0] par_n,
   input  logic           ser_clk,
   input  logic           ser_data,
   input  logic           ser_load,
   input  logic           fb_div_in,
   input  logic           synth_clk_in,
   output logic [M_W-1:0] m_reg,
   output logic [N_W-1:0] n_reg,
   output logic [T_W-1:0] tsel,
   output logic           test_out,
   output logic           m_valid
);

   localparam int WORD_W = T_W + N_W + M_W;
   localparam int PAR_W  = M_W + N_W;
   localparam logic [M_W-1:0] LOCK_LO = M_W'(M_LOCK_MIN);
   localparam logic [M_W-1:0] LOCK_HI = M_W'(M_LOCK_MAX);
   localparam logic [M_W-1:0] M_INIT  = M_W'(M_RESET);

   // Elaboration-time parameter checks
   if (T_W != 2) begin : g_bad_tw
      $error("divcfg_loader: T_W must be 2 to steer the test mux");
   end
   if (M_LOCK_MIN > M_LOCK_MAX) begin : g_bad_range
      $error("divcfg_loader: lock range is empty");
   end
   if (M_LOCK_MAX >= (1 << M_W) || M_RESET >= (1 << M_W)) begin : g_bad_mw
      $error("divcfg_loader: M_W too narrow for range or reset value");
   end

   // Control synchronizer: {par_load_n, ser_clk, ser_load, ser_data}
   logic [3:0] ctl_raw, ctl_s;
   assign ctl_raw = {par_load_n, ser_clk, ser_load, ser_data};

   divcfg_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_ctl_sync (
      .clk (clk),
      .rst (rst),
      .d   (ctl_raw),
      .q   (ctl_s)
   );

   logic pln_s, sclk_s, sl_s, sdata_s;
   assign {pln_s, sclk_s, sl_s, sdata_s} = ctl_s;

   // Parallel data synchronizer, kept aligned with the strobe
   logic [PAR_W-1:0] par_s;

   divcfg_sync #(.W(PAR_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_par_sync (
      .clk (clk),
      .rst (rst),
      .d   ({par_m, par_n}),
      .q   (par_s)
   );

   // Edge detectors
   logic sclk_rise, sclk_fall, sl_rise, sl_fall;

   divcfg_edge #(.RST_VAL(1'b0)) u_sclk_edge (
      .clk  (clk),
      .rst  (rst),
      .lvl  (sclk_s),
      .rise (sclk_rise),
      .fall (sclk_fall)
   );

   divcfg_edge #(.RST_VAL(1'b0)) u_sl_edge (
      .clk  (clk),
      .rst  (rst),
      .lvl  (sl_s),
      .rise (sl_rise),
      .fall (sl_fall)
   );

   logic par_act;
   assign par_act = ~pln_s;

   // Serial shift register, frozen in parallel mode
   logic [WORD_W-1:0] sh_word, sh_next;
   logic              shift_en;
   assign shift_en = sclk_rise & ~par_act;

   divcfg_shift #(.W(WORD_W)) u_shift (
      .clk       (clk),
      .rst       (rst),
      .en        (shift_en),
      .din       (sdata_s),
      .word      (sh_word),
      .word_next (sh_next)
   );

   // Held configuration registers
   logic [T_W-1:0] t_q;
   logic           pass_evt, xfer_evt;
   assign pass_evt = shift_en & sl_s;
   assign xfer_evt = sl_rise & ~par_act;

   always_ff @(posedge clk) begin
      if (rst) begin
         m_reg <= M_INIT;
         n_reg <= '0;
         t_q   <= '0;
      end else if (par_act) begin
         m_reg <= par_s[PAR_W-1:N_W];
         n_reg <= par_s[N_W-1:0];
         t_q   <= '0;
      end else if (pass_evt) begin
         {t_q, n_reg, m_reg} <= sh_next;
      end else if (xfer_evt) begin
         {t_q, n_reg, m_reg} <= sh_word;
      end
   end

   assign tsel = t_q;

   divcfg_testmux u_mux (
      .sel      (t_q),
      .sdata_in (ser_data),
      .fb_in    (fb_div_in),
      .synth_in (synth_clk_in),
      .out      (test_out)
   );

   assign m_valid = (m_reg >= LOCK_LO) && (m_reg <= LOCK_HI);

   // Falling-edge strobes are detected but only the level matters for freezing
   logic unused_edges;
   assign unused_edges = sclk_fall ^ sl_fall;

endmodule

// File: rtl/divcfg_loader_chk.sv
module divcfg_loader_chk #(
   parameter int M_W        = 9,
   parameter int N_W        = 2,
   parameter int T_W        = 2,
   parameter int M_LOCK_MIN = 125,
   parameter int M_RESET    = 200
) (
   input logic           clk,
   input logic           rst,
   input logic           par_act,
   input logic           sl_s,
   input logic [M_W-1:0] m_reg,
   input logic [N_W-1:0] n_reg,
   input logic [T_W-1:0] tsel,
   input logic           test_out,
   input logic           m_valid,
   input logic           fb_div_in
);

   localparam logic [M_W-1:0] C_MIN  = M_W'(M_LOCK_MIN);
   localparam logic [M_W-1:0] C_INIT = M_W'(M_RESET);

   // R1
   rst_values_chk: assert property (@(posedge clk)
      rst |=> (m_reg == C_INIT && n_reg == '0 && tsel == '0));

   // R7
   par_tsel_chk: assert property (@(posedge clk) disable iff (rst)
      par_act |=> (tsel == '0));

   // R5
   hold_regs_chk: assert property (@(posedge clk) disable iff (rst)
      (!par_act && !sl_s) |=> $stable({m_reg, n_reg, tsel}));

   // R8
   mux_low_chk: assert property (@(posedge clk) disable iff (rst)
      (tsel == 2'b00) |-> !test_out);

   // R8
   mux_fb_chk: assert property (@(posedge clk) disable iff (rst)
      (tsel == 2'b10) |-> (test_out == fb_div_in));

   // R9
   low_m_invalid_chk: assert property (@(posedge clk) disable iff (rst)
      (m_reg < C_MIN) |-> !m_valid);

endmodule

bind divcfg_loader divcfg_loader_chk #(
   .M_W(M_W), .N_W(N_W), .T_W(T_W), .M_LOCK_MIN(M_LOCK_MIN), .M_RESET(M_RESET)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .par_act   (par_act),
   .sl_s      (sl_s),
   .m_reg     (m_reg),
   .n_reg     (n_reg),
   .tsel      (tsel),
   .test_out  (test_out),
   .m_valid   (m_valid),
   .fb_div_in (fb_div_in)
);

// File: tb/sim_divcfg_loader.sv
module sim_divcfg_loader;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       par_load_n = 1'b1;
   logic [8:0] par_m = '0;
   logic [1:0] par_n = '0;
   logic       ser_clk = 1'b0;
   logic       ser_data = 1'b0;
   logic       ser_load = 1'b0;
   logic       fb_div_in = 1'b0;
   logic       synth_clk_in = 1'b0;
   logic [8:0] m_reg;
   logic [1:0] n_reg;
   logic [1:0] tsel;
   logic       test_out;
   logic       m_valid;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   divcfg_loader u0 (
      .clk(clk), .rst(rst), .par_load_n(par_load_n), .par_m(par_m), .par_n(par_n),
      .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
      .fb_div_in(fb_div_in), .synth_clk_in(synth_clk_in),
      .m_reg(m_reg), .n_reg(n_reg), .tsel(tsel), .test_out(test_out), .m_valid(m_valid)
   );

   typedef struct {
      logic [8:0] m;
      logic [1:0] n;
      logic [1:0] t;
      string      req;
   } exp_t;

   exp_t sb[$];

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // Monitor: compares queued expectations against the outputs
   initial begin
      forever begin
         @(negedge clk);
         if (sb.size() > 0) begin
            exp_t e;
            logic ev;
            e  = sb.pop_front();
            ev = (e.m >= 9'd125) && (e.m <= 9'd350);
            checks++;
            if (m_reg !== e.m || n_reg !== e.n || tsel !== e.t || m_valid !== ev) begin
               errors++;
               $display("FAIL %s: got m=%0d n=%0d t=%0d v=%0d, expected m=%0d n=%0d t=%0d v=%0d",
                        e.req, m_reg, n_reg, tsel, m_valid, e.m, e.n, e.t, ev);
            end
         end
      end
   end

   task automatic expect_regs(input logic [8:0] m, input logic [1:0] n,
                              input logic [1:0] t, input string req);
      exp_t e;
      repeat (8) @(posedge clk);
      e.m = m; e.n = n; e.t = t; e.req = req;
      sb.push_back(e);
      wait (sb.size() == 0);
      @(posedge clk);
   endtask

   task automatic check_mux(input logic exp, input string req);
      @(negedge clk);
      checks++;
      if (test_out !== exp) begin
         errors++;
         $display("FAIL %s: test_out got %0b expected %0b", req, test_out, exp);
      end
   endtask

   task automatic ser_bit(input logic b);
      ser_data = b;
      repeat (6) @(posedge clk);
      ser_clk = 1'b1;
      repeat (6) @(posedge clk);
      ser_clk = 1'b0;
      repeat (6) @(posedge clk);
   endtask

   task automatic ser_word(input logic [12:0] w);
      for (int i = 12; i >= 0; i--) ser_bit(w[i]);
   endtask

   function automatic logic [12:0] mkw(input logic [1:0] t, input logic [1:0] n,
                                       input logic [8:0] m);
      return {t, n, m};
   endfunction

   // Watchdog
   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      summary();
   end

   initial begin
      logic [12:0] w, p;
      repeat (5) @(posedge clk);
      rst = 1'b0;

      // R1: reset values
      expect_regs(9'd200, 2'd0, 2'd0, "R1");

      // R2: parallel transparency
      par_m = 9'd300; par_n = 2'd2; par_load_n = 1'b0;
      expect_regs(9'd300, 2'd2, 2'd0, "R2");
      par_m = 9'd100;
      expect_regs(9'd100, 2'd2, 2'd0, "R2");

      // R3: latch on rise, later changes ignored
      par_load_n = 1'b1;
      repeat (8) @(posedge clk);
      par_m = 9'd5; par_n = 2'd3;
      expect_regs(9'd100, 2'd2, 2'd0, "R3");

      // R4: shift with load low leaves registers, rise transfers
      ser_word(mkw(2'b10, 2'b01, 9'd125));
      expect_regs(9'd100, 2'd2, 2'd0, "R4");
      ser_load = 1'b1;
      expect_regs(9'd125, 2'd1, 2'd2, "R4");
      // R8: tsel 10 routes fb_div_in
      fb_div_in = 1'b1; check_mux(1'b1, "R8");
      fb_div_in = 1'b0; check_mux(1'b0, "R8");

      // R5: after fall, shifting does not disturb registers
      ser_load = 1'b0;
      repeat (8) @(posedge clk);
      ser_bit(1'b1); ser_bit(1'b1); ser_bit(1'b1);
      w = mkw(2'b11, 2'b11, 9'd350);
      ser_word(w);
      expect_regs(9'd125, 2'd1, 2'd2, "R5");

      // R10: only the last 13 bits are transferred
      ser_load = 1'b1;
      expect_regs(9'd350, 2'd3, 2'd3, "R10");
      // R8: tsel 11 routes synth_clk_in
      synth_clk_in = 1'b1; check_mux(1'b1, "R8");
      synth_clk_in = 1'b0; check_mux(1'b0, "R8");

      // R6: pass-through while load is high
      p = {w[11:0], 1'b0};
      ser_bit(1'b0);
      expect_regs(p[8:0], p[10:9], p[12:11], "R6");
      p = {p[11:0], 1'b1};
      ser_bit(1'b1);
      expect_regs(p[8:0], p[10:9], p[12:11], "R6");

      // R8: tsel 01 routes ser_data
      ser_load = 1'b0;
      repeat (8) @(posedge clk);
      ser_word(mkw(2'b01, 2'b00, 9'd200));
      ser_load = 1'b1;
      expect_regs(9'd200, 2'd0, 2'd1, "R4");
      ser_data = 1'b1; check_mux(1'b1, "R8");
      ser_data = 1'b0; check_mux(1'b0, "R8");
      ser_load = 1'b0;
      repeat (8) @(posedge clk);

      // R7: parallel mode forces tsel 00 and ignores the serial path
      par_m = 9'd250; par_n = 2'd1; par_load_n = 1'b0;
      expect_regs(9'd250, 2'd1, 2'd0, "R7");
      synth_clk_in = 1'b1; fb_div_in = 1'b1;
      check_mux(1'b0, "R7");
      ser_word(mkw(2'b11, 2'b10, 9'd130));
      ser_load = 1'b1;
      repeat (8) @(posedge clk);
      ser_load = 1'b0;
      expect_regs(9'd250, 2'd1, 2'd0, "R7");

      // R9: lock range boundaries
      par_m = 9'd124; expect_regs(9'd124, 2'd1, 2'd0, "R9");
      par_m = 9'd125; expect_regs(9'd125, 2'd1, 2'd0, "R9");
      par_m = 9'd350; expect_regs(9'd350, 2'd1, 2'd0, "R9");
      par_m = 9'd351; expect_regs(9'd351, 2'd1, 2'd0, "R9");
      par_load_n = 1'b1;
      repeat (8) @(posedge clk);

      done = 1;
      summary();
   end

endmodule